// File: doc/BRIEF.md
# In-Band ECC Error Capture Register

This block sits beside an in-band ECC engine and records memory error events for software. Each event arrives as a single-cycle pulse that flags a correctable or an uncorrectable error. The pulse carries the failing byte address and a 16-bit syndrome. The first event is frozen into a 64-bit log word. Its class is also mirrored into a 16-bit status register. An interrupt request is raised when the matching enable bit in a 16-bit command register is set.

Software reads the three registers through a plain select/write/read port. It acknowledges an error by writing ones to the flag bits. Writing back the log value just read clears every flag that was set. The status register is cleared separately, and it must be cleared before the interrupt request drops.

Top module: `ecc_errcap_top`

## Requirements
- R1: After reset the log word, the status register and the command register all read zero, and `irq_req` is low.
- R2: A correctable event sets log bit 62 and status bit 6. An uncorrectable event sets log bit 63 and status bit 7. The new values are visible on the first clock edge after the pulse.
- R3: An event taken while both log flags are clear stores byte-address bits 38:5 into log bits 38:5 and the syndrome into log bits 61:46. All other log bits read zero.
- R4: While either log flag is set, a later event leaves log bits 61:0 unchanged, but it still sets its own log flag and status flag.
- R5: A write to the log (select 0) clears each of bits 62 and 63 that is written as 1. Bits written as 0 are left alone, and the address and syndrome fields are not written.
- R6: A write to the status register (select 1) clears each of bits 6 and 7 that is written as 1. This is independent of the log flags.
- R7: The command register (select 2) stores only bits 6 and 7 of a write, and its other bits read zero. Select 3 reads zero.
- R8: `irq_req` is high while (status bit 6 AND command bit 6) OR (status bit 7 AND command bit 7). It stays high after the log is cleared and drops only once the status flag or the enable is cleared.
- R9: An event in the same cycle as a write-1-to-clear of the same flag leaves that flag set.
- R10: Once both log flags are clear, the next event captures its own address and syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_ce | input | 1 | Correctable error event pulse |
| ev_ue | input | 1 | Uncorrectable error event pulse |
| ev_addr | input | 39 | Failing byte address of the event |
| ev_syn | input | 16 | Syndrome of the event |
| reg_sel | input | 2 | Register select: 0 log, 1 status, 2 command |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| irq_req | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is an event arriving in the very cycle that software writes a one to clear the same flag. The race between the set and the clear decides whether the error is lost. The directed stimulus drives the event pulse and the register write on the same falling edge, so both land on one rising edge. The bench then reads the flag back through the port. A second case is the ordering across the two register pairs: the log is cleared while the status flag is still set. The bench confirms that the interrupt request persists until the status flag itself is written.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
   typedef enum logic [1:0] {
      SEL_LOG  = 2'd0,
      SEL_STS  = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned N_CLASS = 2;   // 0 correctable, 1 uncorrectable
endpackage

// File: rtl/errcap_w1c_bit.sv
module errcap_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

   // R5
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/errcap_capture.sv
module errcap_capture #(
   parameter int unsigned BA_W    = 39,
   parameter int unsigned ADDR_LO = 5,
   parameter int unsigned SYN_W   = 16,
   localparam int unsigned AF_W   = BA_W - ADDR_LO
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [BA_W-1:0]  addr_i,
   input  logic [SYN_W-1:0] syn_i,
   output logic [AF_W-1:0]  addr_o,
   output logic [SYN_W-1:0] syn_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         syn_o  <= '0;
      end else if (load_i) begin
         addr_o <= addr_i[BA_W-1:ADDR_LO];
         syn_o  <= syn_i;
      end
   end

   // R4
   frozen_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(addr_o) && $stable(syn_o)));
endmodule

// File: rtl/ecc_errcap_top.sv
module ecc_errcap_top
   import errcap_pkg::*;
#(
   parameter int unsigned BA_W       = 39,
   parameter int unsigned ADDR_LO    = 5,
   parameter int unsigned SYN_W      = 16,
   parameter int unsigned SYN_LO     = 46,
   parameter int unsigned LOG_W      = 64,
   parameter int unsigned REG_W      = 16,
   parameter int unsigned CE_LOG_BIT = 62,
   parameter int unsigned UE_LOG_BIT = 63,
   parameter int unsigned CE_REG_BIT = 6,
   parameter int unsigned UE_REG_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_ce,
   input  logic             ev_ue,
   input  logic [BA_W-1:0]  ev_addr,
   input  logic [SYN_W-1:0] ev_syn,
   input  logic [1:0]       reg_sel,
   input  logic             reg_wr,
   input  logic [LOG_W-1:0] reg_wdata,
   output logic [LOG_W-1:0] reg_rdata,
   output logic             irq_req
);
   localparam int unsigned AF_W = BA_W - ADDR_LO;

   generate
      if (ADDR_LO + AF_W > SYN_LO) begin : g_bad_addr
         $error("address field overlaps syndrome field");
      end
      if (SYN_LO + SYN_W > CE_LOG_BIT || SYN_LO + SYN_W > UE_LOG_BIT) begin : g_bad_syn
         $error("syndrome field overlaps flag bits");
      end
      if (CE_LOG_BIT >= LOG_W || UE_LOG_BIT >= LOG_W || CE_LOG_BIT == UE_LOG_BIT) begin : g_bad_flag
         $error("log flag positions invalid");
      end
      if (CE_REG_BIT >= REG_W || UE_REG_BIT >= REG_W || REG_W > LOG_W) begin : g_bad_reg
         $error("status/command bit positions invalid");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   logic [N_CLASS-1:0] ev;
   logic [N_CLASS-1:0] log_q, sts_q, cmd_q;
   logic [N_CLASS-1:0] log_clr, sts_clr;
   logic               wr_log, wr_sts, wr_cmd;
   logic               cap_load;
   logic [AF_W-1:0]    fld_addr;
   logic [SYN_W-1:0]   fld_syn;

   assign ev     = {ev_ue, ev_ce};
   assign wr_log = reg_wr && (sel == SEL_LOG);
   assign wr_sts = reg_wr && (sel == SEL_STS);
   assign wr_cmd = reg_wr && (sel == SEL_CMD);

   for (genvar k = 0; k < N_CLASS; k++) begin : g_class
      localparam int unsigned LPOS = (k == 0) ? CE_LOG_BIT : UE_LOG_BIT;
      localparam int unsigned RPOS = (k == 0) ? CE_REG_BIT : UE_REG_BIT;

      assign log_clr[k] = wr_log && reg_wdata[LPOS];
      assign sts_clr[k] = wr_sts && reg_wdata[RPOS];

      errcap_w1c_bit u_log_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ev[k]),
         .clr_i (log_clr[k]),
         .q_o   (log_q[k])
      );

      errcap_w1c_bit u_sts_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ev[k]),
         .clr_i (sts_clr[k]),
         .q_o   (sts_q[k])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cmd_q[k] <= 1'b0;
         else if (wr_cmd) cmd_q[k] <= reg_wdata[RPOS];
      end
   end

   assign cap_load = (|ev) && !(|log_q);

   errcap_capture #(
      .BA_W    (BA_W),
      .ADDR_LO (ADDR_LO),
      .SYN_W   (SYN_W)
   ) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cap_load),
      .addr_i (ev_addr),
      .syn_i  (ev_syn),
      .addr_o (fld_addr),
      .syn_o  (fld_syn)
   );

   logic [LOG_W-1:0] log_word, sts_word, cmd_word;

   always_comb begin
      log_word = '0;
      log_word[ADDR_LO +: AF_W]  = fld_addr;
      log_word[SYN_LO +: SYN_W]  = fld_syn;
      log_word[CE_LOG_BIT]       = log_q[0];
      log_word[UE_LOG_BIT]       = log_q[1];
      sts_word = '0;
      sts_word[CE_REG_BIT]       = sts_q[0];
      sts_word[UE_REG_BIT]       = sts_q[1];
      cmd_word = '0;
      cmd_word[CE_REG_BIT]       = cmd_q[0];
      cmd_word[UE_REG_BIT]       = cmd_q[1];
   end

   always_comb begin
      unique case (sel)
         SEL_LOG: reg_rdata = log_word;
         SEL_STS: reg_rdata = sts_word;
         SEL_CMD: reg_rdata = cmd_word;
         default: reg_rdata = '0;
      endcase
   end

   assign irq_req = |(sts_q & cmd_q);

   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !reg_wr) |=> irq_req);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_req && !(|ev) && !reg_wr) |=> !irq_req);

   // R2
   status_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> (|sts_q) && (|log_q));
endmodule

// File: tb/tb_ecc_errcap_top.sv
module tb_ecc_errcap_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_ce = 1'b0, ev_ue = 1'b0;
   logic [38:0] ev_addr = '0;
   logic [15:0] ev_syn = '0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_wr = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        irq_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ecc_errcap_top dut (
      .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue),
      .ev_addr(ev_addr), .ev_syn(ev_syn), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req)
   );

   function automatic logic [63:0] exp_log(input logic ue, input logic ce,
                                           input logic [38:0] a, input logic [15:0] s);
      return {ue, ce, s, 7'b0, a[38:5], 5'b0};
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] s, output logic [63:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   // one clock: optional write and optional event on the same edge
   task automatic cyc(input logic wr, input logic [1:0] s, input logic [63:0] wd,
                      input logic ce, input logic ue,
                      input logic [38:0] a, input logic [15:0] sy);
      @(negedge clk);
      reg_wr = wr; reg_sel = s; reg_wdata = wd;
      ev_ce = ce; ev_ue = ue; ev_addr = a; ev_syn = sy;
      @(negedge clk);
      reg_wr = 1'b0; ev_ce = 1'b0; ev_ue = 1'b0;
   endtask

   task automatic t_reset;
      logic [63:0] v;
      rd(2'd0, v); chk("R1 log", v, 64'h0);
      rd(2'd1, v); chk("R1 status", v, 64'h0);
      rd(2'd2, v); chk("R1 command", v, 64'h0);
      chk("R1 irq", {63'b0, irq_req}, 64'h0);
   endtask

   task automatic t_capture_hold;
      logic [63:0] v;
      cyc(0, 2'd0, 0, 1, 0, 39'h12_3456_789F, 16'hBEEF);
      rd(2'd0, v); chk("R2/R3 ce capture", v, exp_log(0, 1, 39'h12_3456_789F, 16'hBEEF));
      rd(2'd1, v); chk("R2 status ce", v, 64'h40);
      chk("R8 irq off without enable", {63'b0, irq_req}, 64'h0);
      cyc(0, 2'd0, 0, 0, 1, 39'h7F_0000_1234, 16'h1357);
      rd(2'd0, v); chk("R4 fields held", v, exp_log(1, 1, 39'h12_3456_789F, 16'hBEEF));
      rd(2'd1, v); chk("R2 status ue", v, 64'hC0);
   endtask

   task automatic t_clear;
      logic [63:0] v, lg;
      rd(2'd0, lg);
      cyc(1, 2'd0, 64'h4000_0000_0000_0000, 0, 0, 0, 0);
      rd(2'd0, v); chk("R5 partial clear", v, exp_log(1, 0, 39'h12_3456_789F, 16'hBEEF));
      rd(2'd0, lg);
      cyc(1, 2'd0, lg, 0, 0, 0, 0);
      rd(2'd0, v); chk("R5 write-back clear", v & 64'hC000_0000_0000_0000, 64'h0);
      chk("R5 fields unwritten", v, exp_log(0, 0, 39'h12_3456_789F, 16'hBEEF));
      rd(2'd1, v); chk("R6 status independent", v, 64'hC0);
      cyc(1, 2'd1, 64'h40, 0, 0, 0, 0);
      rd(2'd1, v); chk("R6 clear bit6", v, 64'h80);
      cyc(1, 2'd1, 64'h80, 0, 0, 0, 0);
      rd(2'd1, v); chk("R6 clear bit7", v, 64'h0);
   endtask

   task automatic t_recapture;
      logic [63:0] v;
      cyc(0, 2'd0, 0, 0, 1, 39'h01_0203_0405, 16'hA5A5);
      rd(2'd0, v); chk("R10 new capture", v, exp_log(1, 0, 39'h01_0203_0405, 16'hA5A5));
      cyc(1, 2'd0, 64'hC000_0000_0000_0000, 0, 0, 0, 0);
      cyc(1, 2'd1, 64'hFFFF, 0, 0, 0, 0);
      rd(2'd0, v); chk("R5 clear both", v[63:62], 64'h0);
   endtask

   task automatic t_irq;
      logic [63:0] v;
      cyc(1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0);
      rd(2'd2, v); chk("R7 command bits", v, 64'hC0);
      rd(2'd3, v); chk("R7 select 3", v, 64'h0);
      cyc(0, 2'd0, 0, 0, 1, 39'h00_0000_0100, 16'h0001);
      chk("R8 irq raised", {63'b0, irq_req}, 64'h1);
      cyc(1, 2'd0, 64'hC000_0000_0000_0000, 0, 0, 0, 0);
      chk("R8 irq survives log clear", {63'b0, irq_req}, 64'h1);
      cyc(1, 2'd1, 64'h80, 0, 0, 0, 0);
      chk("R8 irq drops", {63'b0, irq_req}, 64'h0);
      cyc(1, 2'd2, 64'h80, 0, 0, 0, 0);
      cyc(0, 2'd0, 0, 1, 0, 39'h00_0000_0200, 16'h0002);
      chk("R8 ce masked", {63'b0, irq_req}, 64'h0);
      cyc(1, 2'd2, 64'h40, 0, 0, 0, 0);
      chk("R8 enable raises", {63'b0, irq_req}, 64'h1);
      cyc(1, 2'd2, 64'h0, 0, 0, 0, 0);
      chk("R8 disable drops", {63'b0, irq_req}, 64'h0);
      cyc(1, 2'd0, 64'hC000_0000_0000_0000, 0, 0, 0, 0);
      cyc(1, 2'd1, 64'hC0, 0, 0, 0, 0);
   endtask

   task automatic t_collide;
      logic [63:0] v;
      cyc(1, 2'd0, 64'h4000_0000_0000_0000, 1, 0, 39'h00_0000_0400, 16'h0003);
      rd(2'd0, v); chk("R9 log flag kept", v[63:62], 64'h1);
      cyc(1, 2'd1, 64'h40, 1, 0, 39'h00_0000_0400, 16'h0003);
      rd(2'd1, v); chk("R9 status flag kept", v, 64'h40);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture_hold();
      t_clear();
      t_recapture();
      t_irq();
      t_collide();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule